// File: doc/BRIEF.md
# Inbound Slave Address and Byte-Lane Translator

This block sits between the slave side of an external parallel bus and an internal big-endian system bus. An external master selects the block with an active-low chip select and performs reads, single writes (word or sub-word) or eight-beat burst writes. The block samples the external word address in the cycle that the protocol defines for each transfer type. It joins that word address with the upper bits of a programmable inbound base register, forms the low address bits and the transfer size from the active-low byte enables, and issues one registered request per transfer or per burst beat.

Data can pass through a lane exchange that reverses the four bytes of a word. The exchange applies to write data going inward and to read data going outward. It is suppressed when the formed address falls inside the window of the controller's own local registers. The block also drives the output-enable for the external data pins.

Top module: `inbound_xlate`

## Requirements
- R1: A read (chip select falling with read strobe low) produces a request in the next cycle with write flag 0, size code 2'b10 (word), address {base[31:AW+2], external word address from the first chip-select cycle, 2'b00}. Later address values in the same transfer are not used and no second request is issued.
- R2: A single write (burst low in the first chip-select cycle) uses the address, byte enables and data from the last cycle in which chip select is low. It produces one request in the cycle after chip select returns high, and none while chip select is low.
- R3: A burst write (burst high in the first chip-select cycle) carries one data beat per chip-select cycle, with beat k in cycle k, k = 0..7. The word address is sampled in cycle 1 only. Beat k is requested in the cycle after cycle k+1, at word address sampled+k (byte address +4k, modulo the AW-bit window). Data cycles after the eighth are ignored.
- R4: Byte enables decode to the low address bits and the size code (00 byte, 01 halfword, 10 word), with bit i active meaning byte offset i: 1110→0/byte, 1101→1/byte, 1011→2/byte, 0111→3/byte, 1100→0/half, 0011→2/half, 0000→0/word.
- R5: Any other byte-enable pattern raises the illegal flag with the request, with size 2'b10 and low address bits 00. The data is still passed.
- R6: Byte offset 0 is data bits 31:24. With swap enabled, write data and read return data are byte-reversed (bytes 0↔3, 1↔2).
- R7: Requests whose formed address matches LOC_BASE in bits 31:LOC_LSB are flagged local, and their data is never swapped. For reads, this rule governs the return data.
- R8: The data output-enable is high exactly while chip select and the read strobe are both low.
- R9: After reset, no request is valid and the data output-enable is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| burst | input | 1 | Burst indicator, sampled in the first chip-select cycle |
| addr | input | AW | External word address |
| be_n | input | 4 | Byte enables, active low |
| wdata | input | 32 | External write data |
| base_addr | input | 32 | Inbound base register value |
| swap_en | input | 1 | Byte-lane swap enable |
| sys_rdata | input | 32 | Read data from the system bus |
| data_oe | output | 1 | Output enable for the external data pins |
| ext_rdata | output | 32 | Read data toward the external pins |
| o_valid | output | 1 | Request valid, one cycle |
| o_write | output | 1 | Request is a write |
| o_addr | output | 32 | System byte address |
| o_size | output | 2 | Size code |
| o_wdata | output | 32 | Write data after optional swap |
| o_be_err | output | 1 | Illegal byte-enable pattern |
| o_local | output | 1 | Address hits the local register window |

## Verification
In a burst, the cycle that samples the address is also the cycle that releases beat 0. Beat 0's data was held from the cycle before. The last beat, in turn, is released while a surplus data cycle is being refused. The bench drives a deliberately wrong address and byte enables in every cycle except the one the protocol names. It then compares each beat's address, size and data with values computed from the sampled word plus the beat index. The lane-swap decision is taken on the same formed address in the same cycle. The bench therefore repeats every sweep with the base placed inside and outside the local window, and with swap on and off.

// File: rtl/inbound_xlate.sv
module inbound_xlate #(
  parameter int          AW       = 8,
  parameter logic [31:0] LOC_BASE = 32'hFFFF_F000,
  parameter int          LOC_LSB  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cs_n,
  input  logic          rd_n,
  input  logic          wr_n,
  input  logic          burst,
  input  logic [AW-1:0] addr,
  input  logic [3:0]    be_n,
  input  logic [31:0]   wdata,
  input  logic [31:0]   base_addr,
  input  logic          swap_en,
  input  logic [31:0]   sys_rdata,
  output logic          data_oe,
  output logic [31:0]   ext_rdata,
  output logic          o_valid,
  output logic          o_write,
  output logic [31:0]   o_addr,
  output logic [1:0]    o_size,
  output logic [31:0]   o_wdata,
  output logic          o_be_err,
  output logic          o_local
);
  localparam int BEATS = 8;
  localparam int CW    = $clog2(BEATS + 1);

  function automatic logic [31:0] swap32(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic hits_local(input logic [31:0] a);
    return a[31:LOC_LSB] == LOC_BASE[31:LOC_LSB];
  endfunction

  logic          cs_q, brst_q, h_v, rd_loc_q;
  logic [CW-1:0] bcnt;
  logic [AW-1:0] h_addr, bw_q;
  logic [3:0]    h_be;
  logic [31:0]   h_data;

  wire cs_act   = !cs_n;
  wire cs_start = cs_act && !cs_q;
  wire is_wr    = cs_act && !wr_n && rd_n;
  wire rd_go    = cs_start && !rd_n;
  wire brst_now = cs_start ? burst : brst_q;
  wire [CW-1:0] bcnt_eff = cs_start ? '0 : bcnt;
  wire lat      = is_wr && (!brst_now || bcnt_eff < CW'(BEATS));
  wire emit_s   = cs_q && !cs_act && h_v && !brst_q;
  wire emit_b   = cs_q && h_v && brst_q;
  wire emit     = emit_s || emit_b;

  wire [CW-1:0] bidx    = bcnt - 1'b1;
  wire [AW-1:0] b_base  = (bcnt == CW'(1)) ? addr : bw_q;
  wire [AW-1:0] em_word = emit_b ? b_base + AW'(bidx) : h_addr;

  logic [1:0] lo, sz;
  logic       bad;
  always_comb begin
    lo = 2'd0; sz = 2'd2; bad = 1'b0;
    case (h_be)
      4'b1110: begin lo = 2'd0; sz = 2'd0; end
      4'b1101: begin lo = 2'd1; sz = 2'd0; end
      4'b1011: begin lo = 2'd2; sz = 2'd0; end
      4'b0111: begin lo = 2'd3; sz = 2'd0; end
      4'b1100: begin lo = 2'd0; sz = 2'd1; end
      4'b0011: begin lo = 2'd2; sz = 2'd1; end
      4'b0000: begin lo = 2'd0; sz = 2'd2; end
      default: bad = 1'b1;
    endcase
  end

  wire [31:0] em_addr = {base_addr[31:AW+2], em_word, lo};
  wire [31:0] rd_addr = {base_addr[31:AW+2], addr, 2'b00};
  wire        em_loc  = hits_local(em_addr);
  wire        rd_loc  = hits_local(rd_addr);

  assign data_oe   = cs_act && !rd_n;
  assign ext_rdata = (swap_en && !rd_loc_q) ? swap32(sys_rdata) : sys_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b0; brst_q <= 1'b0; h_v <= 1'b0; rd_loc_q <= 1'b0;
      bcnt <= '0; h_addr <= '0; bw_q <= '0; h_be <= 4'hF; h_data <= '0;
      o_valid <= 1'b0; o_write <= 1'b0; o_addr <= '0; o_size <= 2'd0;
      o_wdata <= '0; o_be_err <= 1'b0; o_local <= 1'b0;
    end else begin
      cs_q <= cs_act;
      if (cs_start) brst_q <= burst;
      if (cs_start)  bcnt <= lat ? CW'(1) : '0;
      else if (lat)  bcnt <= bcnt + 1'b1;
      h_v <= lat;
      if (lat) begin
        h_addr <= addr;
        h_be   <= be_n;
        h_data <= wdata;
      end
      if (emit_b && bcnt == CW'(1)) bw_q <= addr;
      if (rd_go) rd_loc_q <= rd_loc;
      o_valid <= rd_go || emit;
      if (rd_go) begin
        o_write  <= 1'b0;
        o_addr   <= rd_addr;
        o_size   <= 2'd2;
        o_wdata  <= '0;
        o_be_err <= 1'b0;
        o_local  <= rd_loc;
      end else if (emit) begin
        o_write  <= 1'b1;
        o_addr   <= em_addr;
        o_size   <= sz;
        o_wdata  <= (swap_en && !em_loc) ? swap32(h_data) : h_data;
        o_be_err <= bad;
        o_local  <= em_loc;
      end
    end
  end
endmodule

// File: rtl/inbound_xlate_chk.sv
module inbound_xlate_chk #(
  parameter int AW = 8
) (
  input logic        clk,
  input logic        rst_n,
  input logic        cs_n,
  input logic        rd_n,
  input logic        data_oe,
  input logic        o_valid,
  input logic        o_write,
  input logic [31:0] o_addr,
  input logic [1:0]  o_size,
  input logic        o_be_err,
  input logic        brst_q
);
  p_read_req_r1: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(cs_n) && !rd_n) |=> (o_valid && !o_write && o_size == 2'd2 && o_addr[1:0] == 2'd0));

  p_single_after_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_write && !brst_q) |-> ($past(cs_n) && !$past(cs_n, 2)));

  p_beat_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_write && $past(o_valid) && $past(o_write))
      |-> o_addr[AW+1:2] == $past(o_addr[AW+1:2]) + 1'b1);

  p_half_align_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_size == 2'd1) |-> !o_addr[0]);

  p_illegal_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && o_be_err) |-> (o_write && o_size == 2'd2 && o_addr[1:0] == 2'd0));

  p_read_had_oe_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (o_valid && !o_write) |-> $past(data_oe));
endmodule

bind inbound_xlate inbound_xlate_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .data_oe(data_oe),
  .o_valid(o_valid), .o_write(o_write), .o_addr(o_addr), .o_size(o_size),
  .o_be_err(o_be_err), .brst_q(brst_q)
);

// File: tb/sim_inbound_xlate.sv
module sim_inbound_xlate;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, burst = 1'b0, swap_en = 1'b0;
  logic [7:0]  addr = '0;
  logic [3:0]  be_n = 4'hF;
  logic [31:0] wdata = '0, base_addr = '0, sys_rdata = '0;
  logic        data_oe, o_valid, o_write, o_be_err, o_local;
  logic [31:0] ext_rdata, o_addr, o_wdata;
  logic [1:0]  o_size;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  inbound_xlate u0 (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] sw(input logic [31:0] d);
    return {d[7:0], d[15:8], d[23:16], d[31:24]};
  endfunction

  function automatic logic is_loc(input logic [31:0] a);
    return a[31:8] == 24'hFFFFF0;
  endfunction

  task automatic dec(input logic [3:0] be, output logic [1:0] lo, output logic [1:0] sz, output logic bad);
    bad = 1'b0; lo = 2'd0; sz = 2'd2;
    case (be)
      4'b1110: begin lo = 0; sz = 0; end
      4'b1101: begin lo = 1; sz = 0; end
      4'b1011: begin lo = 2; sz = 0; end
      4'b0111: begin lo = 3; sz = 0; end
      4'b1100: begin lo = 0; sz = 1; end
      4'b0011: begin lo = 2; sz = 1; end
      4'b0000: begin lo = 0; sz = 2; end
      default: bad = 1'b1;
    endcase
  endtask

  task automatic chk_write(input string req, input logic [7:0] word, input logic [3:0] be, input logic [31:0] d);
    logic [1:0] lo, sz; logic bad; logic [31:0] ea; logic loc;
    dec(be, lo, sz, bad);
    ea  = {base_addr[31:10], word, lo};
    loc = is_loc(ea);
    chk({req, " valid"}, 32'(o_valid), 1);
    chk({req, " write"}, 32'(o_write), 1);
    chk({req, " addr R4"}, o_addr, ea);
    chk({req, " size R4"}, 32'(o_size), 32'(sz));
    chk({req, " illegal R5"}, 32'(o_be_err), 32'(bad));
    chk({req, " local R7"}, 32'(o_local), 32'(loc));
    chk({req, " data R6"}, o_wdata, (swap_en && !loc) ? sw(d) : d);
  endtask

  task automatic idle();
    cs_n = 1; rd_n = 1; wr_n = 1; burst = 0;
    @(posedge clk); @(negedge clk);
  endtask

  task automatic do_read(input logic [7:0] word, input logic [31:0] rdat);
    logic [31:0] ea; logic loc;
    ea = {base_addr[31:10], word, 2'b00};
    loc = is_loc(ea);
    cs_n = 0; rd_n = 0; addr = word; sys_rdata = rdat;
    @(posedge clk); @(negedge clk);
    chk("R1 valid", 32'(o_valid), 1);
    chk("R1 write", 32'(o_write), 0);
    chk("R1 addr", o_addr, ea);
    chk("R1 size", 32'(o_size), 2);
    chk("R7 read local", 32'(o_local), 32'(loc));
    chk("R8 oe on", 32'(data_oe), 1);
    addr = ~word;
    @(posedge clk); @(negedge clk);
    chk("R1 single request", 32'(o_valid), 0);
    chk("R6 R7 read data", ext_rdata, (swap_en && !loc) ? sw(rdat) : rdat);
    rd_n = 1;
    #1 chk("R8 oe off strobe high", 32'(data_oe), 0);
    idle();
    chk("R8 oe idle", 32'(data_oe), 0);
  endtask

  task automatic do_single(input int n, input logic [7:0] word, input logic [3:0] be, input logic [31:0] d);
    for (int i = 0; i < n; i++) begin
      cs_n = 0; wr_n = 0; burst = 0;
      addr  = (i == n - 1) ? word : ~word;
      be_n  = (i == n - 1) ? be : ~be;
      wdata = (i == n - 1) ? d : ~d;
      @(posedge clk); @(negedge clk);
      chk("R2 no request while selected", 32'(o_valid), 0);
      chk("R8 oe low on write", 32'(data_oe), 0);
    end
    cs_n = 1; wr_n = 1; addr = 8'h00; be_n = 4'h5; wdata = 32'hDEAD_BEEF;
    @(posedge clk); @(negedge clk);
    chk_write("R2", word, be, d);
    idle();
    chk("R2 one request", 32'(o_valid), 0);
  endtask

  task automatic do_burst(input logic [7:0] word, input int seed);
    logic [3:0] bes[9]; logic [31:0] ds[9];
    for (int k = 0; k < 9; k++) begin
      bes[k] = 4'((k * 5 + seed) % 16);
      ds[k]  = 32'h0102_0304 * (k + 1) + 32'(seed);
    end
    cs_n = 0; wr_n = 0; burst = 1; addr = ~word; be_n = bes[0]; wdata = ds[0];
    @(posedge clk); @(negedge clk);
    chk("R3 no beat yet", 32'(o_valid), 0);
    for (int k = 1; k <= 8; k++) begin
      burst = 0;
      addr  = (k == 1) ? word : ~word;
      be_n  = bes[k]; wdata = ds[k];
      @(posedge clk); @(negedge clk);
      chk_write("R3 beat", word + 8'(k - 1), bes[k-1], ds[k-1]);
    end
    cs_n = 1; wr_n = 1;
    @(posedge clk); @(negedge clk);
    chk("R3 surplus ignored", 32'(o_valid), 0);
    idle();
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R9 reset valid", 32'(o_valid), 0);
    chk("R9 reset oe", 32'(data_oe), 0);
    rst_n = 1;
    idle();
    chk("R9 idle valid", 32'(o_valid), 0);
    for (int s = 0; s < 2; s++)
      for (int l = 0; l < 2; l++)
        for (int b = 0; b < 16; b++) begin
          swap_en   = s[0];
          base_addr = l[0] ? 32'hFFFF_F000 : 32'h4000_0000;
          do_single(1 + b % 3, l[0] ? 8'h05 : 8'(8'h40 + b), 4'(b),
                    32'h11223344 ^ {4'(b), 28'h0ABCDEF});
        end
    for (int w = 0; w < 256; w++) begin
      swap_en   = w[0];
      base_addr = (w % 3 == 0) ? 32'hFFFF_F000 : 32'h8000_0C00;
      do_read(8'(w), 32'hA1B2C3D4 + 32'(w));
    end
    for (int s = 0; s < 2; s++)
      for (int l = 0; l < 2; l++) begin
        swap_en   = s[0];
        base_addr = l[0] ? 32'hFFFF_F000 : 32'h2000_0000;
        do_burst(l[0] ? 8'h02 : 8'hFC, s * 7 + l * 3);
      end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule